// File: doc/BRIEF.md
# Vector clip-high compare unit

This block performs an eight-lane high-clip test on 16-bit signed elements. Each lane compares a value `a` against a limit `b` that may be positive or negative. When the two operands disagree in sign, the lane judges the value against the magnitude of the limit using their sum. When the signs agree, the lane uses their difference. Each lane yields a clipped element and a handful of flag bits.

The flags are gathered into three words:
- a 16-bit compare word holding greater-equal and less-equal bits;
- a 16-bit carry/not-equal word;
- an 8-bit extension word that marks lanes whose sum is exactly -1.

A single-cycle `start` strobe captures both source vectors. At the same clock edge the clipped vector is registered onto the accumulator-low and destination outputs, and all three flag words are registered with it. A one-cycle `done` pulse follows. Lane i always occupies bits [16i+15:16i] of every 128-bit vector.

Top module: `vclip_hi_unit`

## Requirements
- R1: After reset, `done` is 0 and every result and flag output is 0.
- R2: A `start` sampled high at a clock edge loads results and all three flag words at that edge, so `done` is 1 for the following cycle. Without `start`, `done` is 0 and every output holds its value, whatever the sources do.
- R3: A lane takes the split-sign path exactly when bit 15 of `a` XOR `b` is 1. Otherwise it takes the same-sign path.
- R4: On the split-sign path with sum = a + b computed without overflow, the following bits are set:
  - compare bit 8+i (greater-equal) is (b < 0);
  - compare bit i (less-equal) is (sum <= 0);
  - carry bit i (bit i of the carry/not-equal word) is 1.
- R5: On the split-sign path, extension bit i is 1 exactly when sum == -1. Not-equal bit 8+i of the carry/not-equal word is 1 exactly when sum is neither 0 nor -1.
- R6: On the split-sign path, the lane result is -b when less-equal is 1, otherwise a. Negating -32768 gives -32768 (0x8000).
- R7: On the same-sign path, the following bits are set, with the difference computed without overflow:
  - less-equal is (b < 0);
  - greater-equal is (a - b >= 0);
  - not-equal is (a != b);
  - carry bit i and extension bit i are 0.
- R8: On the same-sign path, the lane result is b when greater-equal is 1, otherwise a.
- R9: `acc_lo` and `vd_out` carry the same clipped vector after every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture strobe for one operation |
| src_a | input | 128 | Eight value elements, lane i at [16i+15:16i] |
| src_b | input | 128 | Eight limit elements, same lane layout |
| done | output | 1 | High one cycle after a captured start |
| acc_lo | output | 128 | Clipped vector for the accumulator low slice |
| vd_out | output | 128 | Clipped vector for the destination register |
| cmp_flags | output | 16 | [15:8] greater-equal, [7:0] less-equal |
| cn_flags | output | 16 | [15:8] not-equal, [7:0] carry |
| ext_flags | output | 8 | Sum equal to -1, one bit per lane |

## Verification
The assertions assume that `start` is a synchronous strobe. They also assume that every operand bit pattern is legal: no input combination is excluded, including -32768 limits and sums of exactly 0 or -1. The stimulus changes operands and `start` only on falling edges. It drives vectors that mix both paths in one operation and cover the extreme values. This keeps every clocked property well defined at each rising edge.

// File: rtl/vch_pkg.sv
package vch_pkg;
   typedef struct packed {
      logic ge;
      logic le;
      logic carry;
      logic ne;
      logic ext;
   } vch_flags_t;
endpackage

// File: rtl/vch_lane.sv
module vch_lane
   import vch_pkg::*;
#(
   parameter int EW = 16,
   parameter bit EXT_BY_COMPLEMENT = 1'b1
) (
   input  logic [EW-1:0] a,
   input  logic [EW-1:0] b,
   output logic [EW-1:0] res,
   output vch_flags_t    flg
);
   localparam int XW = EW + 1;

   logic signed [XW-1:0] ax, bx, sum, dif;
   logic split, sum_zero, sum_m1;
   logic [EW-1:0] neg_b;

   assign ax       = $signed({a[EW-1], a});
   assign bx       = $signed({b[EW-1], b});
   assign sum      = ax + bx;
   assign dif      = ax - bx;
   assign split    = a[EW-1] ^ b[EW-1];
   assign sum_zero = (sum == '0);
   assign neg_b    = ~b + 1'b1;

   generate
      if (EXT_BY_COMPLEMENT) begin : g_ext_cmpl
         assign sum_m1 = (a == ~b);
      end else begin : g_ext_sum
         assign sum_m1 = (sum == '1);
      end
   endgenerate

   always_comb begin
      if (split) begin
         flg.ge    = b[EW-1];
         flg.le    = sum[XW-1] | sum_zero;
         flg.carry = 1'b1;
         flg.ext   = sum_m1;
         flg.ne    = ~(sum_zero | sum_m1);
         res       = flg.le ? neg_b : a;
      end else begin
         flg.le    = b[EW-1];
         flg.ge    = ~dif[XW-1];
         flg.carry = 1'b0;
         flg.ext   = 1'b0;
         flg.ne    = (a != b);
         res       = flg.ge ? b : a;
      end
   end
endmodule

// File: rtl/vch_outreg.sv
module vch_outreg
   import vch_pkg::*;
#(
   parameter int LANES = 8,
   parameter int EW    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [LANES*EW-1:0] res_in,
   input  vch_flags_t          flg_in [LANES],
   output logic                done,
   output logic [LANES*EW-1:0] res_q,
   output logic [2*LANES-1:0]  cmp_q,
   output logic [2*LANES-1:0]  cn_q,
   output logic [LANES-1:0]    ext_q
);
   logic [2*LANES-1:0] cmp_d, cn_d;
   logic [LANES-1:0]   ext_d;

   for (genvar i = 0; i < LANES; i++) begin : g_pack
      assign cmp_d[LANES+i] = flg_in[i].ge;
      assign cmp_d[i]       = flg_in[i].le;
      assign cn_d[LANES+i]  = flg_in[i].ne;
      assign cn_d[i]        = flg_in[i].carry;
      assign ext_d[i]       = flg_in[i].ext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         res_q <= '0;
         cmp_q <= '0;
         cn_q  <= '0;
         ext_q <= '0;
      end else begin
         done <= start;
         if (start) begin
            res_q <= res_in;
            cmp_q <= cmp_d;
            cn_q  <= cn_d;
            ext_q <= ext_d;
         end
      end
   end
endmodule

// File: rtl/vclip_hi_unit.sv
module vclip_hi_unit
   import vch_pkg::*;
#(
   parameter int LANES = 8,
   parameter int EW    = 16,
   parameter bit EXT_BY_COMPLEMENT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [LANES*EW-1:0] src_a,
   input  logic [LANES*EW-1:0] src_b,
   output logic                done,
   output logic [LANES*EW-1:0] acc_lo,
   output logic [LANES*EW-1:0] vd_out,
   output logic [2*LANES-1:0]  cmp_flags,
   output logic [2*LANES-1:0]  cn_flags,
   output logic [LANES-1:0]    ext_flags
);
   localparam int VW = LANES * EW;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (EW < 2) begin : g_bad_ew
         $error("EW must be at least 2");
      end
   endgenerate

   logic [VW-1:0] res_w, res_q;
   vch_flags_t    flg_w [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      vch_lane #(.EW(EW), .EXT_BY_COMPLEMENT(EXT_BY_COMPLEMENT)) u_lane (
         .a   (src_a[i*EW +: EW]),
         .b   (src_b[i*EW +: EW]),
         .res (res_w[i*EW +: EW]),
         .flg (flg_w[i])
      );
   end

   vch_outreg #(.LANES(LANES), .EW(EW)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .res_in (res_w),
      .flg_in (flg_w),
      .done   (done),
      .res_q  (res_q),
      .cmp_q  (cmp_flags),
      .cn_q   (cn_flags),
      .ext_q  (ext_flags)
   );

   assign acc_lo = res_q;
   assign vd_out = res_q;

   AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done); // R2
   AST_DONE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done); // R2
   AST_HOLD_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(vd_out) && $stable(cmp_flags) && $stable(cn_flags) && $stable(ext_flags))); // R2
   AST_EXT_CLEARS_NE: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_flags & cn_flags[2*LANES-1:LANES]) == '0); // R5
   AST_EXT_NEEDS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_flags & ~cn_flags[LANES-1:0]) == '0); // R7
endmodule

// File: tb/vclip_hi_unit_test.sv
module vclip_hi_unit_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] src_a = '0, src_b = '0;
   logic         done;
   logic [127:0] acc_lo, vd_out;
   logic [15:0]  cmp_flags, cn_flags;
   logic [7:0]   ext_flags;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   vclip_hi_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
      .done(done), .acc_lo(acc_lo), .vd_out(vd_out),
      .cmp_flags(cmp_flags), .cn_flags(cn_flags), .ext_flags(ext_flags)
   );

   task automatic check(input string tag, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void model(input logic [127:0] a, input logic [127:0] b,
                                 output logic [127:0] r, output logic [15:0] cmp,
                                 output logic [15:0] cn, output logic [7:0] ext);
      r = '0; cmp = '0; cn = '0; ext = '0;
      for (int i = 0; i < 8; i++) begin
         int x, y, s, d, rv;
         logic ge, le;
         x = int'($signed(a[16*i +: 16]));
         y = int'($signed(b[16*i +: 16]));
         if ((x < 0) != (y < 0)) begin
            s = x + y;
            ge = (y < 0);
            le = (s <= 0);
            ext[i]  = (s == -1);
            cn[8+i] = !(s == 0 || s == -1);
            cn[i]   = 1'b1;
            rv = le ? -y : x;
         end else begin
            d = x - y;
            le = (y < 0);
            ge = (d >= 0);
            cn[8+i] = (x != y);
            rv = ge ? y : x;
         end
         cmp[8+i] = ge;
         cmp[i]   = le;
         r[16*i +: 16] = rv[15:0];
      end
   endfunction

   task automatic run_op(input string tag, input logic [127:0] a, input logic [127:0] b);
      logic [127:0] er;
      logic [15:0]  ec, en;
      logic [7:0]   ee;
      model(a, b, er, ec, en, ee);
      @(negedge clk);
      src_a = a; src_b = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2", {tag, " done pulse"}, {127'b0, done}, 128'd1);
      check(tag, "compare word", {112'b0, cmp_flags}, {112'b0, ec});
      check(tag, "carry/not-equal word", {112'b0, cn_flags}, {112'b0, en});
      check(tag, "extension word", {120'b0, ext_flags}, {120'b0, ee});
      check(tag, "destination vector", vd_out, er);
      check("R9", {tag, " accumulator copy"}, acc_lo, er);
      @(negedge clk);
      check("R2", {tag, " done falls"}, {127'b0, done}, 128'd0);
   endtask

   function automatic logic [127:0] v8(input int e7, e6, e5, e4, e3, e2, e1, e0);
      return {e7[15:0], e6[15:0], e5[15:0], e4[15:0], e3[15:0], e2[15:0], e1[15:0], e0[15:0]};
   endfunction

   task automatic test_reset();
      check("R1", "done after reset", {127'b0, done}, 128'd0);
      check("R1", "vector after reset", vd_out, '0);
      check("R1", "flags after reset", {88'b0, cmp_flags, cn_flags, ext_flags}, '0);
   endtask

   task automatic test_same_sign();
      run_op("R7,R8 same-sign",
             v8(100, 50, -5, -200, 0, 7, 32767, -32768),
             v8(50, 100, -10, -100, 0, 7, 1, -1));
   endtask

   task automatic test_split_sign();
      run_op("R3,R4,R5,R6 split-sign",
             v8(5, -5, 100, -100, 0, -1, 32767, -32768),
             v8(-5, 5, -3, 3, -1, 0, -32768, 32767));
   endtask

   task automatic test_edges();
      run_op("R6 negate wrap",
             v8(5, 0, 32767, 1, -2, 3, -32768, 0),
             v8(-32768, -32768, -32768, -1, 1, -4, 0, -32768));
      run_op("R3 mixed paths",
             v8(-1, 0, -1, 0, 40, -40, 40, -40),
             v8(-1, 0, 0, -1, -41, 39, 41, -39));
   endtask

   task automatic test_hold();
      logic [127:0] v_before;
      logic [15:0]  c_before;
      v_before = vd_out;
      c_before = cmp_flags;
      @(negedge clk);
      src_a = v8(1, 2, 3, 4, 5, 6, 7, 8);
      src_b = v8(-9, -9, -9, -9, 9, 9, 9, 9);
      repeat (3) @(negedge clk);
      check("R2", "vector held without start", vd_out, v_before);
      check("R2", "compare held without start", {112'b0, cmp_flags}, {112'b0, c_before});
      check("R2", "done low without start", {127'b0, done}, 128'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_same_sign();
      test_split_sign();
      test_edges();
      test_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule